// File: doc/BRIEF.md
# Write-Once Fuse Array Controller

This block is a register-mapped controller for a one-time-programmable fuse array held in on-chip flops. Software reaches it through a simple 32-bit request/response port: it loads a word address, a bit position and a data value into configuration registers, then pulses a program-enable register to burn a single bit. A shadow map of written flags, one per fuse bit, rejects every later attempt to program the same bit. This keeps the write-once behaviour of a real fuse.

Fuse words are read through a read-only data-out register. That register returns the word at the current address only while three separate enable registers all have their enable bit set. At reset every fuse word is all ones, except a serial-number word at a parameterised index and its bitwise complement in the word after it. A set of test and timing registers is kept only so that software can read it back. None of these registers changes the behaviour of the block.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: After reset, every configuration, program-enable and test register reads 0, and a data-out read with the enables off returns 0x000000FF.
- R2: The seven test registers at byte offsets 0x24, 0x28, 0x2C, 0x30, 0x34, 0x38 and 0x3C read back exactly the 32-bit value last written. Writing them changes nothing else.
- R3: A data-out read (offset 0x20) returns the fuse word at the current address only when bit 0 of chip-enable (0x10), strobe-enable (0x14) and trim-enable (0x18) are all 1. In every other case it returns 0x000000FF. Other bits of these three registers do not matter.
- R4: Writes to data-out are accepted without error and have no effect on any register or fuse word.
- R5: A write to the address register (offset 0x00) stores only the low ADDR_W bits of the data. Read-back shows the masked value.
- R6: The program-enable register (offset 0x1C) keeps only bit 0 of a write.
- R7: A write to program-enable with bit 0 set, while the redundancy register (0x0C) is zero, programs one fuse bit. Word (address register) bit (bit-index register 0x04, low 5 bits) takes the value of bit 0 of data-in (0x08). That fuse bit's written flag is then set.
- R8: A program write while the redundancy register is nonzero changes no fuse bit and sets no flag.
- R9: A program write to a bit whose written flag is already set leaves the fuse word unchanged.
- R10: At reset, fuse word SERIAL_IDX holds SERIAL_VAL, word SERIAL_IDX+1 holds ~SERIAL_VAL, and every other word holds 0xFFFFFFFF.
- R11: An access is unmapped when its offset is not 4-byte aligned or is at or above 0x40. An unmapped access has no effect, and its response carries rsp_err=1 with data 0.
- R12: Each accepted request gets exactly one response. It comes with rsp_valid high in the cycle after the request, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data (0 for writes and unmapped accesses) |
| rsp_err | output | 1 | Unmapped access flag, one cycle with rsp_valid |

## Verification
The checker assumes that at most one request is presented per cycle and that the request fields stay stable only for the cycle in which req_valid is high. It also assumes that the address register is not rewritten in the same cycle as a program write, so the addressed word can be compared before and after that write. The bench drives every access as a single-cycle pulse from a task and performs each step of a program sequence as its own access. Because of this, a program write never overlaps an address change, and the stimulus stays inside these assumptions.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
   localparam int DATA_W    = 32;
   localparam int OFS_W     = 8;
   localparam int BIT_W     = $clog2(DATA_W);
   localparam int NUM_TEST  = 7;
   localparam int TEST_BASE = 9;
   localparam logic [DATA_W-1:0] DOUT_BLOCKED = 32'h0000_00FF;

   typedef enum logic [3:0] {
      RG_ADDR = 4'd0, RG_BIT  = 4'd1, RG_DIN  = 4'd2,  RG_RED  = 4'd3,
      RG_CEN  = 4'd4, RG_STB  = 4'd5, RG_TRIM = 4'd6,  RG_PWE  = 4'd7,
      RG_DOUT = 4'd8, RG_T0   = 4'd9, RG_T1   = 4'd10, RG_T2   = 4'd11,
      RG_T3   = 4'd12, RG_T4  = 4'd13, RG_T5  = 4'd14, RG_T6   = 4'd15
   } reg_sel_e;

   typedef struct packed {
      logic     hit;
      reg_sel_e sel;
   } dec_t;

   function automatic dec_t decode_ofs(input logic [OFS_W-1:0] ofs);
      dec_t d;
      d.hit = (ofs[1:0] == 2'b00) && (ofs[OFS_W-1:6] == '0);
      d.sel = reg_sel_e'(ofs[5:2]);
      return d;
   endfunction
endpackage

// File: rtl/fuse_cfg_regs.sv
module fuse_cfg_regs
   import fuse_ctrl_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_cfg,
   output logic [ADDR_W-1:0] fuse_addr,
   output logic [BIT_W-1:0]  bit_idx,
   output logic              prog_val,
   output logic              redund_off,
   output logic              dout_en
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] bit_q, din_q, red_q, cen_q, stb_q, trim_q;
   logic              pwe_q;
   logic [NUM_TEST-1:0][DATA_W-1:0] test_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         bit_q  <= '0;
         din_q  <= '0;
         red_q  <= '0;
         cen_q  <= '0;
         stb_q  <= '0;
         trim_q <= '0;
         pwe_q  <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            RG_ADDR: addr_q <= wdata[ADDR_W-1:0];
            RG_BIT:  bit_q  <= wdata;
            RG_DIN:  din_q  <= wdata;
            RG_RED:  red_q  <= wdata;
            RG_CEN:  cen_q  <= wdata;
            RG_STB:  stb_q  <= wdata;
            RG_TRIM: trim_q <= wdata;
            RG_PWE:  pwe_q  <= wdata[0];
            default: ;
         endcase
      end
   end

   for (genvar t = 0; t < NUM_TEST; t++) begin : g_test
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            test_q[t] <= '0;
         else if (wr_en && (sel == reg_sel_e'(4'(TEST_BASE + t))))
            test_q[t] <= wdata;
      end
   end

   always_comb begin
      rd_cfg = '0;
      case (sel)
         RG_ADDR: rd_cfg = DATA_W'(addr_q);
         RG_BIT:  rd_cfg = bit_q;
         RG_DIN:  rd_cfg = din_q;
         RG_RED:  rd_cfg = red_q;
         RG_CEN:  rd_cfg = cen_q;
         RG_STB:  rd_cfg = stb_q;
         RG_TRIM: rd_cfg = trim_q;
         RG_PWE:  rd_cfg = DATA_W'(pwe_q);
         default: begin
            for (int t = 0; t < NUM_TEST; t++)
               if (sel == reg_sel_e'(4'(TEST_BASE + t)))
                  rd_cfg = test_q[t];
         end
      endcase
   end

   assign fuse_addr  = addr_q;
   assign bit_idx    = bit_q[BIT_W-1:0];
   assign prog_val   = din_q[0];
   assign redund_off = (red_q == '0);
   assign dout_en    = cen_q[0] & stb_q[0] & trim_q[0];
endmodule

// File: rtl/fuse_store.sv
module fuse_store
   import fuse_ctrl_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                SERIAL_IDX = 252,
   parameter logic [DATA_W-1:0] SERIAL_VAL = 32'hC0DE_0042
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_req,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [BIT_W-1:0]  prog_bit,
   input  logic              prog_val,
   input  logic [ADDR_W-1:0] look_addr,
   output logic [DATA_W-1:0] look_word,
   output logic [DATA_W-1:0] look_flags
);
   localparam int WORDS = 1 << ADDR_W;

   logic [WORDS-1:0][DATA_W-1:0] words_flat;
   logic [WORDS-1:0][DATA_W-1:0] flags_flat;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [DATA_W-1:0] INIT =
         (w == SERIAL_IDX)     ? SERIAL_VAL  :
         (w == SERIAL_IDX + 1) ? ~SERIAL_VAL : '1;
      logic [DATA_W-1:0] word_r, flag_r;
      logic              burn;

      assign burn = prog_req && (prog_addr == ADDR_W'(w)) && !flag_r[prog_bit];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_r <= INIT;
            flag_r <= '0;
         end else if (burn) begin
            word_r[prog_bit] <= prog_val;
            flag_r[prog_bit] <= 1'b1;
         end
      end

      assign words_flat[w] = word_r;
      assign flags_flat[w] = flag_r;
   end

   assign look_word  = words_flat[look_addr];
   assign look_flags = flags_flat[look_addr];
endmodule

// File: rtl/fuse_rsp.sv
module fuse_rsp
   import fuse_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  dec_t              dec,
   input  logic [DATA_W-1:0] rd_cfg,
   input  logic [DATA_W-1:0] fuse_word,
   input  logic              dout_en,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   logic [DATA_W-1:0] rd_sel;

   always_comb begin
      if (dec.sel == RG_DOUT)
         rd_sel = dout_en ? fuse_word : DOUT_BLOCKED;
      else
         rd_sel = rd_cfg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !dec.hit;
         rsp_rdata <= (req_valid && !req_write && dec.hit) ? rd_sel : '0;
      end
   end
endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
   import fuse_ctrl_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                SERIAL_IDX = 252,
   parameter logic [DATA_W-1:0] SERIAL_VAL = 32'hC0DE_0042
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [OFS_W-1:0]  req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("fuse_prog_ctrl: ADDR_W must lie in 1..12");
   end
   if (SERIAL_IDX < 0 || SERIAL_IDX + 1 >= (1 << ADDR_W)) begin : g_bad_serial
      $error("fuse_prog_ctrl: serial word pair must fit inside the array");
   end

   dec_t              dec;
   logic              cfg_wr, prog_fire;
   logic [DATA_W-1:0] rd_cfg, cur_word, cur_flags;
   logic [ADDR_W-1:0] addr_q;
   logic [BIT_W-1:0]  bit_idx;
   logic              prog_val, redund_off, dout_en;

   assign dec       = decode_ofs(req_addr);
   assign cfg_wr    = req_valid && req_write && dec.hit;
   assign prog_fire = cfg_wr && (dec.sel == RG_PWE) && req_wdata[0] && redund_off;

   fuse_cfg_regs #(.ADDR_W(ADDR_W)) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr),
      .sel        (dec.sel),
      .wdata      (req_wdata),
      .rd_cfg     (rd_cfg),
      .fuse_addr  (addr_q),
      .bit_idx    (bit_idx),
      .prog_val   (prog_val),
      .redund_off (redund_off),
      .dout_en    (dout_en)
   );

   fuse_store #(
      .ADDR_W     (ADDR_W),
      .SERIAL_IDX (SERIAL_IDX),
      .SERIAL_VAL (SERIAL_VAL)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_req   (prog_fire),
      .prog_addr  (addr_q),
      .prog_bit   (bit_idx),
      .prog_val   (prog_val),
      .look_addr  (addr_q),
      .look_word  (cur_word),
      .look_flags (cur_flags)
   );

   fuse_rsp rsp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .dec       (dec),
      .rd_cfg    (rd_cfg),
      .fuse_word (cur_word),
      .dout_en   (dout_en),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .rsp_err   (rsp_err)
   );
endmodule

// File: rtl/fuse_prog_ctrl_chk.sv
module fuse_prog_ctrl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [7:0]        req_addr,
   input logic [31:0]       req_wdata,
   input logic              rsp_valid,
   input logic [31:0]       rsp_rdata,
   input logic              rsp_err,
   input logic [ADDR_W-1:0] addr_q,
   input logic [4:0]        bit_idx,
   input logic [31:0]       cur_word,
   input logic [31:0]       cur_flags,
   input logic              prog_fire,
   input logic              dout_en
);
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R12
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R12
   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == 32'h0)); // R11
   AST_ADDR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == 8'h00) |=> addr_q == $past(req_wdata[ADDR_W-1:0])); // R5
   AST_DOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == 8'h20 && !dout_en) |=> rsp_rdata == 32'hFF); // R3
   AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_fire && cur_flags[bit_idx]) |=> $stable(cur_word)); // R9
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      prog_fire |=> cur_flags[$past(bit_idx)]); // R7
endmodule

bind fuse_prog_ctrl fuse_prog_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .rsp_err   (rsp_err),
   .addr_q    (addr_q),
   .bit_idx   (bit_idx),
   .cur_word  (cur_word),
   .cur_flags (cur_flags),
   .prog_fire (prog_fire),
   .dout_en   (dout_en)
);

// File: tb/fuse_prog_ctrl_tb_top.sv
module fuse_prog_ctrl_tb_top;
   localparam int          AW     = 8;
   localparam int          NW     = 1 << AW;
   localparam int          SIDX   = 252;
   localparam logic [31:0] SVAL   = 32'hC0DE_0042;
   localparam logic [7:0]  O_ADDR = 8'h00, O_BIT = 8'h04, O_DIN = 8'h08, O_RED = 8'h0C,
                           O_CEN  = 8'h10, O_STB = 8'h14, O_TRIM = 8'h18, O_PWE = 8'h1C,
                           O_DOUT = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] exp_word [NW];
   logic [31:0] exp_flag [NW];

   always #4 clk = ~clk;

   fuse_prog_ctrl #(.ADDR_W(AW), .SERIAL_IDX(SIDX), .SERIAL_VAL(SVAL)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic err, output logic vld);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      rd = rsp_rdata; err = rsp_err; vld = rsp_valid;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] r; logic e, v;
      access(1'b1, a, d, r, e, v);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] r);
      logic e, v;
      access(1'b0, a, 32'h0, r, e, v);
   endtask

   task automatic read_word(input int w, output logic [31:0] r);
      wr(O_ADDR, 32'(w));
      rd(O_DOUT, r);
   endtask

   task automatic prog(input int w, input int b, input logic v);
      wr(O_ADDR, 32'(w));
      wr(O_BIT, 32'(b));
      wr(O_DIN, {31'h0, v});
      wr(O_PWE, 32'h1);
      if (!exp_flag[w][b % 32]) begin
         exp_word[w][b % 32] = v;
         exp_flag[w][b % 32] = 1'b1;
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r; logic e, v;
      for (int w = 0; w < NW; w++) begin
         exp_word[w] = (w == SIDX) ? SVAL : (w == SIDX + 1) ? ~SVAL : 32'hFFFF_FFFF;
         exp_flag[w] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 no response while idle", {31'h0, rsp_valid}, 32'h0);

      // R1: reset state of every register
      for (int o = 0; o < 16; o++) begin
         if (o == 8) continue;
         access(1'b0, 8'(o * 4), 32'h0, r, e, v);
         chk("R1 register reset value", r, 32'h0);
         chk("R12 read response valid", {31'h0, v}, 32'h1);
      end
      rd(O_DOUT, r);
      chk("R1 dout blocked after reset", r, 32'hFF);

      // R2: test registers hold written values
      for (int t = 0; t < 7; t++) wr(8'(8'h24 + t * 4), 32'hA5A5_0000 + 32'(t * 32'h1111));
      for (int t = 0; t < 7; t++) begin
         rd(8'(8'h24 + t * 4), r);
         chk("R2 test register readback", r, 32'hA5A5_0000 + 32'(t * 32'h1111));
      end
      rd(O_ADDR, r);
      chk("R2 test writes leave address", r, 32'h0);

      // R3: enable gating, only bit 0 of each enable matters
      wr(O_ADDR, SIDX);
      for (int m = 0; m < 8; m++) begin
         wr(O_CEN,  {30'h0, 1'b1, m[0]});
         wr(O_STB,  {30'h0, 1'b1, m[1]});
         wr(O_TRIM, {30'h0, 1'b1, m[2]});
         rd(O_DOUT, r);
         chk("R3 dout gating", r, (m == 7) ? SVAL : 32'hFF);
      end

      // R10: reset contents of the whole array
      for (int w = 0; w < NW; w++) begin
         read_word(w, r);
         chk("R10 reset fuse word", r, exp_word[w]);
      end

      // R5 and R6: masking of address and program-enable
      wr(O_ADDR, 32'hFFFF_FF37);
      rd(O_ADDR, r);
      chk("R5 address masked", r, 32'h37);
      wr(O_RED, 32'h1);
      wr(O_PWE, 32'hFFFF_FFFE);
      rd(O_PWE, r);
      chk("R6 program-enable keeps bit 0 (0)", r, 32'h0);
      wr(O_PWE, 32'hFFFF_FFFF);
      rd(O_PWE, r);
      chk("R6 program-enable keeps bit 0 (1)", r, 32'h1);

      // R8: redundancy nonzero blocks programming
      wr(O_RED, 32'h4);
      wr(O_ADDR, 32'd5); wr(O_BIT, 32'd3); wr(O_DIN, 32'h0); wr(O_PWE, 32'h1);
      rd(O_DOUT, r);
      chk("R8 redundancy blocks program", r, exp_word[5]);
      wr(O_RED, 32'h0);

      // R4: writes to dout are ignored
      wr(O_DOUT, 32'h1234_5678);
      rd(O_DOUT, r);
      chk("R4 dout write ignored", r, exp_word[5]);
      rd(O_ADDR, r);
      chk("R4 dout write leaves address", r, 32'd5);

      // R7: program of word 5 bit 3 now succeeds (flag untouched by R8 attempt)
      prog(5, 3, 1'b0);
      read_word(5, r);
      chk("R7 program after blocked attempt", r, exp_word[5]);
      // R7: bit index uses low 5 bits (37 -> bit 5)
      prog(6, 37, 1'b0);
      read_word(6, r);
      chk("R7 bit index low bits", r, 32'hFFFF_FFDF);

      // R7/R9: exhaustive bit sweep over a few words, then a second program
      for (int k = 0; k < 4; k++) begin
         automatic int w = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? SIDX : NW - 1;
         for (int b = 0; b < 32; b++) begin
            prog(w, b, ((w + b) % 3) == 0);
            rd(O_DOUT, r);
            chk("R7 single-bit program", r, exp_word[w]);
         end
         for (int b = 0; b < 32; b++) begin
            prog(w, b, ((w + b) % 3) != 0);
            rd(O_DOUT, r);
            chk("R9 second program rejected", r, exp_word[w]);
         end
      end

      // R7: one program in every word, then read the array back
      for (int w = 0; w < NW; w++) prog(w, (w * 7) % 32, 1'b0);
      for (int w = 0; w < NW; w++) begin
         read_word(w, r);
         chk("R7 array sweep", r, exp_word[w]);
      end

      // R11: unmapped and misaligned accesses
      access(1'b0, 8'h40, 32'h0, r, e, v);
      chk("R11 unmapped read data", r, 32'h0);
      chk("R11 unmapped read err", {31'h0, e}, 32'h1);
      access(1'b1, 8'h01, 32'hFFFF_FFFF, r, e, v);
      chk("R11 misaligned write err", {31'h0, e}, 32'h1);
      rd(O_ADDR, r);
      chk("R11 misaligned write ignored", r, 32'(NW - 1));
      access(1'b0, 8'h22, 32'h0, r, e, v);
      chk("R11 misaligned read data", r, 32'h0);
      access(1'b0, O_DOUT, 32'h0, r, e, v);
      chk("R11 mapped access no err", {31'h0, e}, 32'h0);
      @(negedge clk);
      chk("R12 single response", {31'h0, rsp_valid}, 32'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule